// File: doc/BRIEF.md
# Packed 12-bit symbol error applicator

This block applies the output of a Reed-Solomon decoder to a page held in a byte-wide single-port RAM. The page has 2048 data bytes and then a spare area. The code uses 12-bit symbols, and every two symbols are packed into three bytes. Symbol 0 is a short 8-bit symbol at byte 0. Each later symbol spans two adjacent bytes. Odd symbols take a whole byte and then the high nibble of the next byte. Even symbols take the low nibble of one byte and then the whole next byte. Symbol 1365 crosses from the last data byte into the first spare byte. The block addresses the page as one flat space, with the spare area starting at address 2048. Because of that, the crossing symbol follows the ordinary odd rule.

A start pulse loads an error count and up to four position/pattern pairs. The block first checks the whole page. The page is rejected if the count is above four, if any listed position lies past the end of the codeword, or if the short symbol's pattern does not fit in eight bits. A rejected page makes no RAM access and increments a fail counter. An accepted page is patched one byte at a time, each byte with a read-modify-write. The block then adds the number of listed symbols to a running corrected counter. A one-cycle done pulse ends every request.

Top module: `nfix_apply`

## Requirements
- R1: For an odd position p up to 1374, the byte at address floor(3p/2) is XORed with pattern bits 11:4. The byte at the next address is XORed with pattern bits 3:0 shifted into its high nibble.
- R2: For an even position p from 2 to 1374, the byte at address 3p/2-1 is XORed with pattern bits 11:8 in its low nibble. The byte at address 3p/2 is XORed with pattern bits 7:0.
- R3: At position 0, a pattern of 0xFF or less is XORed into byte 0. A larger pattern rejects the page.
- R4: Position 1365 changes data byte 2047 with pattern bits 11:4. It changes the high nibble of spare byte 0 (address 2048) with pattern bits 3:0.
- R5: Positions 1366 to 1374 follow R1 and R2 and land in spare addresses 2048 to 2061. No access is made above address 2061.
- R6: A listed position above 1374 in any slot below the count rejects the whole page.
- R7: An error count above 4 rejects the page. Slots at or above the count are ignored, whatever they hold.
- R8: A rejected page makes no RAM access. It pulses done_o with fail_o high, one cycle after the start is taken. It increments fail_cnt_o and leaves corr_cnt_o unchanged.
- R9: An accepted page pulses done_o with fail_o low and adds the error count to corr_cnt_o. A count of 0 finishes one cycle after the start.
- R10: Every byte fix is a read followed by a write to the same address. Slots are applied in order, so symbols that share a byte both take effect.
- R11: An accepted page that touches B bytes raises done_o 1+2B cycles after the start edge.
- R12: A start pulse during a request has no effect on the RAM, the counters or the number of done pulses.
- R13: After reset, done_o, fail_o and the RAM enable are low and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, taken only when idle |
| err_cnt_i | input | 3 | Number of valid slots |
| err_loc_i | input | 44 | Four 11-bit symbol positions, slot 0 in the low bits |
| err_pat_i | input | 48 | Four 12-bit error patterns, slot 0 in the low bits |
| mem_en_o | output | 1 | RAM access enable |
| mem_we_o | output | 1 | RAM write (read when low) |
| mem_addr_o | output | 12 | RAM byte address |
| mem_wdata_o | output | 8 | RAM write data |
| mem_rdata_i | input | 8 | RAM read data, one cycle after the read |
| done_o | output | 1 | One-cycle end-of-request pulse |
| fail_o | output | 1 | Page rejected, valid with done_o |
| corr_cnt_o | output | 16 | Running count of corrected symbols |
| fail_cnt_o | output | 16 | Running count of rejected pages |

## Verification
The start pulse is sampled on one edge, and validation takes the next edge. A rejected page or an empty list therefore shows done_o after exactly one more edge. Each touched byte adds two edges, one for the read and one for the write, so a page touching B bytes finishes 1+2B edges after the start. The bench computes B from the positions and counts edges from the start edge to the first falling-edge sample with done_o high. It compares that count with the expected one and reads fail_o and both counters in the same sample. The bench then checks its RAM copy against an arithmetic model of the page, after done and before the next start.

// File: rtl/nfix_pkg.sv
package nfix_pkg;
  localparam int SYM_W = 12;
  typedef enum logic [1:0] {ST_IDLE, ST_CHK, ST_RD, ST_WR} nfix_state_e;
endpackage

// File: rtl/nfix_map.sv
// Symbol position -> byte address and XOR masks (flat page address space)
module nfix_map import nfix_pkg::*; #(
  parameter int POS_W  = 11,
  parameter int ADDR_W = 12
) (
  input  logic [POS_W-1:0]  pos_i,
  input  logic [SYM_W-1:0]  pat_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [7:0]        xor_lo_o,
  output logic [7:0]        xor_hi_o,
  output logic              two_o
);
  logic [POS_W+1:0] pos3;
  logic [POS_W:0]   half;

  always_comb begin
    pos3 = {2'b00, pos_i} + {1'b0, pos_i, 1'b0};
    half = pos3[POS_W+1:1];
    two_o = (pos_i != '0);
    if (pos_i == '0) begin
      base_o   = '0;
      xor_lo_o = pat_i[7:0];
      xor_hi_o = 8'h00;
    end else if (pos_i[0]) begin
      base_o   = ADDR_W'(half);
      xor_lo_o = pat_i[11:4];
      xor_hi_o = {pat_i[3:0], 4'h0};
    end else begin
      base_o   = ADDR_W'(half - 1'b1);
      xor_lo_o = {4'h0, pat_i[11:8]};
      xor_hi_o = pat_i[7:0];
    end
  end
endmodule

// File: rtl/nfix_check.sv
// Whole-page acceptance test over the captured slots
module nfix_check import nfix_pkg::*; #(
  parameter int MAX_ERR  = 4,
  parameter int POS_W    = 11,
  parameter int NCNT_W   = 3,
  parameter int LAST_POS = 1374
) (
  input  logic [NCNT_W-1:0] cnt_i,
  input  logic [POS_W-1:0]  loc_i [MAX_ERR],
  input  logic [SYM_W-1:0]  pat_i [MAX_ERR],
  output logic              bad_o
);
  always_comb begin
    bad_o = (int'(cnt_i) > MAX_ERR);
    for (int i = 0; i < MAX_ERR; i++) begin
      if (i < int'(cnt_i)) begin
        if (int'(loc_i[i]) > LAST_POS) bad_o = 1'b1;
        if (loc_i[i] == '0 && pat_i[i][SYM_W-1:8] != '0) bad_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/nfix_seq.sv
module nfix_seq import nfix_pkg::*; #(
  parameter int MAX_ERR  = 4,
  parameter int POS_W    = 11,
  parameter int ADDR_W   = 12,
  parameter int NCNT_W   = 3,
  parameter int CNT_W    = 16,
  parameter int LAST_POS = 1374
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [NCNT_W-1:0]         cnt_i,
  input  logic [MAX_ERR*POS_W-1:0]  loc_i,
  input  logic [MAX_ERR*SYM_W-1:0]  pat_i,
  output logic [NCNT_W-1:0]         cnt_q_o,
  output logic [POS_W-1:0]          loc_q_o [MAX_ERR],
  output logic [SYM_W-1:0]          pat_q_o [MAX_ERR],
  input  logic                      bad_i,
  input  logic [ADDR_W-1:0]         base_i [MAX_ERR],
  input  logic [7:0]                xlo_i [MAX_ERR],
  input  logic [7:0]                xhi_i [MAX_ERR],
  input  logic [MAX_ERR-1:0]        two_i,
  output logic                      mem_en_o,
  output logic                      mem_we_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic [7:0]                mem_wdata_o,
  input  logic [7:0]                mem_rdata_i,
  output logic                      done_o,
  output logic                      fail_o,
  output logic [CNT_W-1:0]          corr_cnt_o,
  output logic [CNT_W-1:0]          fail_cnt_o
);
  localparam int IDX_W     = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;
  localparam int LAST_BYTE = (LAST_POS * 3) / 2 + (LAST_POS % 2);

  nfix_state_e       state_q;
  logic [NCNT_W-1:0] slot_q;
  logic              byte_q;
  logic [IDX_W-1:0]  idx;
  logic [7:0]        cur_xor;

  assign idx     = IDX_W'(slot_q);
  assign cur_xor = byte_q ? xhi_i[idx] : xlo_i[idx];

  assign mem_en_o    = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_addr_o  = base_i[idx] + ADDR_W'(byte_q);
  assign mem_wdata_o = mem_rdata_i ^ cur_xor;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      slot_q     <= '0;
      byte_q     <= 1'b0;
      cnt_q_o    <= '0;
      done_o     <= 1'b0;
      fail_o     <= 1'b0;
      corr_cnt_o <= '0;
      fail_cnt_o <= '0;
      for (int i = 0; i < MAX_ERR; i++) begin
        loc_q_o[i] <= '0;
        pat_q_o[i] <= '0;
      end
    end else begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          cnt_q_o <= cnt_i;
          for (int i = 0; i < MAX_ERR; i++) begin
            loc_q_o[i] <= loc_i[i*POS_W +: POS_W];
            pat_q_o[i] <= pat_i[i*SYM_W +: SYM_W];
          end
          state_q <= ST_CHK;
        end
        ST_CHK: begin
          slot_q <= '0;
          byte_q <= 1'b0;
          if (bad_i) begin
            done_o     <= 1'b1;
            fail_o     <= 1'b1;
            fail_cnt_o <= fail_cnt_o + 1'b1;
            state_q    <= ST_IDLE;
          end else if (cnt_q_o == '0) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_RD;
          end
        end
        ST_RD: state_q <= ST_WR;
        ST_WR: begin
          if (!byte_q && two_i[idx]) begin
            byte_q  <= 1'b1;
            state_q <= ST_RD;
          end else if (slot_q + 1'b1 < cnt_q_o) begin
            slot_q  <= slot_q + 1'b1;
            byte_q  <= 1'b0;
            state_q <= ST_RD;
          end else begin
            done_o     <= 1'b1;
            corr_cnt_o <= corr_cnt_o + CNT_W'(cnt_q_o);
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10
  rmw_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($past(mem_en_o && !mem_we_o) && mem_addr_o == $past(mem_addr_o)));
  // R5
  addr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> (mem_addr_o <= ADDR_W'(LAST_BYTE)));
  // R8
  fail_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fail_o) |-> ($past(state_q) == ST_CHK && !$past(mem_en_o)));
  // R9
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(corr_cnt_o) && $stable(fail_cnt_o)));
  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_en_o);
  // R12
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(cnt_q_o));
endmodule

// File: rtl/nfix_apply.sv
module nfix_apply import nfix_pkg::*; #(
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int MAX_ERR     = 4,
  parameter int POS_W       = 11,
  parameter int LAST_POS    = 1374,
  parameter int CNT_W       = 16,
  localparam int ADDR_W     = $clog2(DATA_BYTES + SPARE_BYTES),
  localparam int NCNT_W     = $clog2(MAX_ERR + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [NCNT_W-1:0]        err_cnt_i,
  input  logic [MAX_ERR*POS_W-1:0] err_loc_i,
  input  logic [MAX_ERR*SYM_W-1:0] err_pat_i,
  output logic                     mem_en_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  output logic [7:0]               mem_wdata_o,
  input  logic [7:0]               mem_rdata_i,
  output logic                     done_o,
  output logic                     fail_o,
  output logic [CNT_W-1:0]         corr_cnt_o,
  output logic [CNT_W-1:0]         fail_cnt_o
);
  logic [NCNT_W-1:0]  cnt_q;
  logic [POS_W-1:0]   loc_q [MAX_ERR];
  logic [SYM_W-1:0]   pat_q [MAX_ERR];
  logic [ADDR_W-1:0]  base  [MAX_ERR];
  logic [7:0]         xlo   [MAX_ERR];
  logic [7:0]         xhi   [MAX_ERR];
  logic [MAX_ERR-1:0] two;
  logic               bad;

  for (genvar g = 0; g < MAX_ERR; g++) begin : g_map
    nfix_map #(.POS_W(POS_W), .ADDR_W(ADDR_W)) u_map (
      .pos_i   (loc_q[g]),
      .pat_i   (pat_q[g]),
      .base_o  (base[g]),
      .xor_lo_o(xlo[g]),
      .xor_hi_o(xhi[g]),
      .two_o   (two[g])
    );
  end

  nfix_check #(.MAX_ERR(MAX_ERR), .POS_W(POS_W), .NCNT_W(NCNT_W),
               .LAST_POS(LAST_POS)) u_check (
    .cnt_i(cnt_q), .loc_i(loc_q), .pat_i(pat_q), .bad_o(bad)
  );

  nfix_seq #(.MAX_ERR(MAX_ERR), .POS_W(POS_W), .ADDR_W(ADDR_W), .NCNT_W(NCNT_W),
             .CNT_W(CNT_W), .LAST_POS(LAST_POS)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .cnt_i      (err_cnt_i),
    .loc_i      (err_loc_i),
    .pat_i      (err_pat_i),
    .cnt_q_o    (cnt_q),
    .loc_q_o    (loc_q),
    .pat_q_o    (pat_q),
    .bad_i      (bad),
    .base_i     (base),
    .xlo_i      (xlo),
    .xhi_i      (xhi),
    .two_i      (two),
    .mem_en_o   (mem_en_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .corr_cnt_o (corr_cnt_o),
    .fail_cnt_o (fail_cnt_o)
  );
endmodule

// File: tb/sim_nfix_apply.sv
`timescale 1ns/1ps
module sim_nfix_apply;
  localparam int NB = 2112;

  logic        clk = 0, rst_n = 0, start = 0;
  logic [2:0]  cnt = 0;
  logic [43:0] locs = 0;
  logic [47:0] pats = 0;
  logic        mem_en, mem_we, done, fail;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] corr_cnt, fail_cnt;

  logic [7:0] ram   [NB];
  logic [7:0] model [NB];
  int total = 0, bad_n = 0;
  int exp_corr = 0, exp_fail = 0;
  int lv [4];
  int pv [4];

  always #2.5 clk = ~clk;

  nfix_apply u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .err_cnt_i(cnt),
    .err_loc_i(locs), .err_pat_i(pats), .mem_en_o(mem_en), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .done_o(done), .fail_o(fail), .corr_cnt_o(corr_cnt), .fail_cnt_o(fail_cnt)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) ram[i] <= 8'(i * 29 + 7);
      mem_rdata <= 8'h00;
    end else if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else mem_rdata <= ram[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad_n++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ram_chk(input string req);
    int mm = 0, first = -1;
    for (int i = 0; i < NB; i++)
      if (ram[i] !== model[i]) begin
        mm++;
        if (first < 0) first = i;
      end
    chk(mm == 0, req, first < 0 ? 0 : int'(ram[first]), first < 0 ? 0 : int'(model[first]));
  endtask

  // Expected result from requirements R1-style packing rules
  task automatic run(input int n, input string req, input bit poke);
    bit rej = (n > 4);
    int nb = 0, cyc = 0, ndone = 0;
    for (int i = 0; i < 4; i++) if (i < n) begin
      if (lv[i] > 1374) rej = 1;
      if (lv[i] == 0 && pv[i] > 255) rej = 1;
    end
    if (!rej) for (int i = 0; i < n; i++) begin
      int p = lv[i], q = pv[i], a;
      if (p == 0) begin
        model[0] ^= 8'(q); nb += 1;
      end else if (p % 2 == 1) begin
        a = (3 * p) / 2;
        model[a] ^= 8'(q >> 4); model[a+1] ^= 8'((q & 15) << 4); nb += 2;
      end else begin
        a = (3 * p) / 2 - 1;
        model[a] ^= 8'(q >> 8); model[a+1] ^= 8'(q & 255); nb += 2;
      end
    end
    @(negedge clk);
    cnt = 3'(n);
    for (int i = 0; i < 4; i++) begin
      locs[i*11 +: 11] = 11'(lv[i]);
      pats[i*12 +: 12] = 12'(pv[i]);
    end
    start = 1;
    @(negedge clk);
    start = 0;
    while (cyc < 100) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (poke && cyc == 1) begin
        locs = ~locs; pats = ~pats; cnt = 3'd1; start = 1;
      end else start = 0;
      if (done) break;
    end
    chk(done === 1'b1 && cyc == (rej ? 1 : 1 + 2 * nb), {req, "/R11 latency"}, cyc, rej ? 1 : 1 + 2 * nb);
    chk(fail === rej, {req, "/R8 fail flag"}, int'(fail), int'(rej));
    if (rej) exp_fail++; else exp_corr += n;
    chk(int'(corr_cnt) == exp_corr, {req, "/R9 corr count"}, int'(corr_cnt), exp_corr);
    chk(int'(fail_cnt) == exp_fail, {req, "/R8 fail count"}, int'(fail_cnt), exp_fail);
    ram_chk({req, " page"});
    if (poke) begin
      start = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (done) ndone++;
      end
      chk(ndone == 0, "R12 extra done", ndone, 0);
      chk(int'(corr_cnt) == exp_corr, "R12 counter", int'(corr_cnt), exp_corr);
      ram_chk("R12 page");
    end
  endtask

  initial begin : wdog
    #(5.0 * 190000);
    bad_n++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad_n);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) model[i] = 8'(i * 29 + 7);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13
    chk(done === 0 && fail === 0 && mem_en === 0, "R13 outputs", int'(done), 0);
    chk(corr_cnt === 0 && fail_cnt === 0, "R13 counters", int'(corr_cnt), 0);

    // single-error sweep across every position and a few beyond the end
    for (int p = 0; p <= 1380; p++) begin
      string t;
      lv = '{p, 0, 0, 0};
      pv = '{(p == 0) ? 'hA5 : (((p * 37 + 5) & 'hFFF) | 1), 0, 0, 0};
      if (p == 0) t = "R3";
      else if (p == 1365) t = "R4";
      else if (p > 1374) t = "R6";
      else if (p > 1365) t = "R5";
      else if (p % 2 == 1) t = "R1";
      else t = "R2";
      run(1, t, 0);
    end
    lv = '{0, 0, 0, 0}; pv = '{'h1A5, 0, 0, 0};
    run(1, "R3 wide", 0);
    lv = '{1, 2, 2, 1364}; pv = '{'hABC, 'h123, 'hF0F, 'h5A5};
    run(4, "R10 overlap", 0);
    lv = '{1365, 1366, 1374, 0}; pv = '{'hFED, 'h0B7, 'h3C9, 'hFF};
    run(4, "R4 seam", 0);
    lv = '{5, 6, 7, 8}; pv = '{1, 2, 3, 4};
    run(5, "R7 count", 0);
    lv = '{10, 11, 12, 1375}; pv = '{'h111, 'h222, 'h333, 'h444};
    run(4, "R6 slot3", 0);
    lv = '{20, 21, 2000, 0}; pv = '{'h9A1, 'h17E, 'hFFF, 'hFFF};
    run(2, "R7 unused", 0);
    run(0, "R9 empty", 0);
    lv = '{100, 0, 0, 0}; pv = '{'h6C3, 0, 0, 0};
    run(1, "R12 busy", 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad_n);
    $finish;
  end
endmodule